// File: doc/BRIEF.md
# TDM Receive Serial Port (Clock-Slave)

This block puts one link's received frame onto a system-side TDM port as two serial streams, one for data and one for signaling. The system side drives the bit clock and the frame pulse. The block runs on a fast core clock, samples both serial inputs and finds their edges. A single frame position counter then steps through 32 timeslots of 8 bits each, 256 bit periods in all. For the current position the block requests the timeslot byte and its 4 signaling bits from a parallel source through `ts_idx`, then shifts them out most significant bit first.

Configuration inputs choose several things:
- which serial clock edge samples the frame pulse;
- which edge updates the outputs;
- whether the serial clock runs at the bit rate or at twice the bit rate, and in the second case which of the two update edges in a bit period is used;
- the frame pulse polarity;
- a timeslot and bit offset between the pulse and the start of the output frame.

Every frame pulse after the first one since reset is checked against the 256-bit grid. A pulse that lands off the grid sets a sticky error flag, which can raise an interrupt when enabled.

Top module: `tdm_rx_port`

## Requirements
- R1: After reset, `ser_dat`, `ser_sig`, `err_flag` and `irq` are 0, and `ser_oe` is 1 while `cfg_hiz` is 0.
- R2: A frame pulse is accepted on the first pulse-sample edge that sees it active: rising when `cfg_fp_fall`=0, falling when it is 1. When the pulse-sample and update edges are the same type, bit 0 of the output frame is driven on that same edge. Bit `k` of the output frame is bit `7-(k mod 8)` of timeslot `k/8`, so each timeslot goes out MSB first. The data output changes only on update edges.
- R3: When the pulse-sample edge and the update edge are of different types (`cfg_dat_fall`=1 selects the falling edge for updates), the pulse counts as early. Bit 0 is then driven on the first update edge after the pulse.
- R4: With `cfg_ts_ofs`=T (0 to 31), the output frame starts T×8 bit periods later than it would with offset 0.
- R5: `cfg_bit_ofs`=B (0 to 7) delays the output frame by a further B bit periods.
- R6: On `ser_sig`, bit positions 4, 5, 6 and 7 of a timeslot carry signaling bits 3, 2, 1 and 0 of that same timeslot. Positions 0 to 3 are 0. This alignment holds for any offset.
- R7: With `cfg_dbl_rate`=1 each bit period spans two serial clock cycles. Of its two update edges, the first is used when `cfg_upd_second`=0 and the second when it is 1.
- R8: With `cfg_fp_inv`=1 the frame pulse is active low.
- R9: The first pulse after reset is not judged. Any later pulse that arrives a whole multiple of 256 bit periods after the previous one leaves `err_flag` unchanged. Any other pulse sets `err_flag`, and it stays set.
- R10: `irq` is 1 exactly when `err_flag` and `cfg_err_ie` are both 1. A one-cycle `err_clr` strobe clears `err_flag`. If a bad pulse arrives in the same cycle as the strobe, the flag stays set.
- R11: `cfg_hiz`=1 drives `ser_oe` to 0, which puts both serial outputs into high impedance at the pad.
- R12: In double-rate mode a pulse held over two pulse-sample edges is accepted only on the first of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | System bit clock |
| ser_fp_i | input | 1 | System frame pulse |
| cfg_fp_fall | input | 1 | Pulse-sample edge: 0 rising, 1 falling |
| cfg_dat_fall | input | 1 | Update edge: 0 rising, 1 falling |
| cfg_dbl_rate | input | 1 | Serial clock at twice the bit rate |
| cfg_upd_second | input | 1 | Double rate: update on the second edge of the bit |
| cfg_fp_inv | input | 1 | Frame pulse active low |
| cfg_ts_ofs | input | 5 | Timeslot offset |
| cfg_bit_ofs | input | 3 | Bit offset |
| cfg_hiz | input | 1 | Force outputs to high impedance |
| cfg_err_ie | input | 1 | Interrupt enable for the pulse error |
| err_clr | input | 1 | Write-one-to-clear strobe for `err_flag` |
| ts_idx | output | 5 | Timeslot requested from the byte source |
| ts_byte | input | 8 | Data byte of timeslot `ts_idx` |
| ts_sig | input | 4 | Signaling bits of timeslot `ts_idx` |
| ser_dat | output | 1 | Serial data |
| ser_sig | output | 1 | Serial signaling |
| ser_oe | output | 1 | Output enable for both serial pins |
| err_flag | output | 1 | Sticky off-grid pulse flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions run on every cycle and cover local rules:
- both serial outputs hold between update events;
- a pulse acceptance never falls on the same core cycle as an update when the two edge types differ;
- the error flag rises only on an accepted pulse, stays set until cleared, and is cleared by the strobe;
- `irq` never appears without `err_flag`.

Other behaviour can only be shown by the bench's scenarios, because it depends on the whole bit stream over a frame and beyond its wrap. This covers the bit order, the timeslot and bit offsets, the early-pulse shift, the choice of edge in double-rate mode, the single acceptance of a held pulse, inverted polarity, and telling grid pulses from off-grid ones.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  // Edge-type selection handed to the edge finder
  typedef struct packed {
    logic fs_fall;   // pulse sampled on falling edge
    logic up_fall;   // outputs updated on falling edge
    logic fs_inv;    // pulse active low
  } edge_sel_t;

endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge
  import tdm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ser_clk_i,
  input  logic      ser_fp_i,
  input  edge_sel_t sel,
  output logic      fs_ev,
  output logic      up_ev,
  output logic      fp_act
);

  logic [SYNC_STAGES-1:0] ck_q, ck_d, fp_q, fp_d;
  logic                   ck_prev_q, ck_prev_d;
  logic                   ck_now, rise, fall;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb begin
        ck_d = {ck_q[SYNC_STAGES-2:0], ser_clk_i};
        fp_d = {fp_q[SYNC_STAGES-2:0], ser_fp_i};
      end
    end else begin : g_single
      always_comb begin
        ck_d = ser_clk_i;
        fp_d = ser_fp_i;
      end
    end
  endgenerate

  assign ck_now    = ck_q[SYNC_STAGES-1];
  assign ck_prev_d = ck_now;
  assign rise      = ck_now & ~ck_prev_q;
  assign fall      = ~ck_now & ck_prev_q;
  assign fs_ev     = sel.fs_fall ? fall : rise;
  assign up_ev     = sel.up_fall ? fall : rise;
  assign fp_act    = fp_q[SYNC_STAGES-1] ^ sel.fs_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q      <= '0;
      fp_q      <= '0;
      ck_prev_q <= 1'b0;
    end else begin
      ck_q      <= ck_d;
      fp_q      <= fp_d;
      ck_prev_q <= ck_prev_d;
    end
  end

endmodule

// File: rtl/tdm_rx_timing.sv
module tdm_rx_timing #(
  parameter int TS_W = 5,
  parameter int BW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_ev,
  input  logic              up_ev,
  input  logic              fp_act,
  input  logic              dbl_rate,
  input  logic              upd_second,
  input  logic [TS_W-1:0]   ts_ofs,
  input  logic [BW-1:0]     bit_ofs,
  input  logic              err_clr,
  output logic [TS_W+BW-1:0] cur_pos,
  output logic              shift_en,
  output logic              fp_hit,
  output logic              err_flag
);

  localparam int CNT_W = TS_W + BW;

  logic [CNT_W-1:0] pos_q, pos_d, load_pos;
  logic             half_q, half_d, half_e;
  logic             fp_prev_q, fp_prev_d;
  logic             armed_q, armed_d;
  logic             err_q, err_d;
  logic             bad_pulse;

  // Position output at the pulse so that position 0 comes ofs bits later
  assign load_pos = -{ts_ofs, bit_ofs};

  always_comb begin
    fp_hit    = fs_ev & fp_act & ~fp_prev_q;
    cur_pos   = fp_hit ? load_pos : pos_q;
    half_e    = fp_hit ? 1'b0 : half_q;
    shift_en  = up_ev & (~dbl_rate | (half_e == upd_second));
    pos_d     = shift_en ? cur_pos + 1'b1 : cur_pos;
    half_d    = up_ev ? ~half_e : half_e;
    fp_prev_d = fs_ev ? fp_act : fp_prev_q;
    bad_pulse = fp_hit & armed_q & (pos_q != load_pos);
    armed_d   = armed_q | fp_hit;
    if (bad_pulse)    err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  assign err_flag = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      half_q    <= 1'b0;
      fp_prev_q <= 1'b0;
      armed_q   <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      pos_q     <= pos_d;
      half_q    <= half_d;
      fp_prev_q <= fp_prev_d;
      armed_q   <= armed_d;
      err_q     <= err_d;
    end
  end

endmodule

// File: rtl/tdm_rx_shift.sv
module tdm_rx_shift #(
  parameter int BITS_PER_TS = 8,
  parameter int SIG_W       = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           shift_en,
  input  logic [$clog2(BITS_PER_TS)-1:0] bit_pos,
  input  logic [BITS_PER_TS-1:0]         ts_byte,
  input  logic [SIG_W-1:0]               ts_sig,
  output logic                           ser_dat,
  output logic                           ser_sig
);

  localparam int BW = $clog2(BITS_PER_TS);
  localparam int SW = (SIG_W > 1) ? $clog2(SIG_W) : 1;

  logic [BW-1:0] ridx;
  logic          dat_bit, sig_bit;
  logic          dat_q, dat_d, sig_q, sig_d;

  always_comb begin
    ridx    = BW'(BITS_PER_TS - 1) - bit_pos;
    dat_bit = ts_byte[ridx];
    sig_bit = (32'(ridx) < SIG_W) ? ts_sig[ridx[SW-1:0]] : 1'b0;
    dat_d   = shift_en ? dat_bit : dat_q;
    sig_d   = shift_en ? sig_bit : sig_q;
  end

  assign ser_dat = dat_q;
  assign ser_sig = sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= 1'b0;
      sig_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      sig_q <= sig_d;
    end
  end

endmodule

// File: rtl/tdm_rx_port.sv
module tdm_rx_port
  import tdm_rx_pkg::*;
#(
  parameter int TS_PER_FRAME = 32,
  parameter int BITS_PER_TS  = 8,
  parameter int SIG_W        = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ser_clk_i,
  input  logic                            ser_fp_i,
  input  logic                            cfg_fp_fall,
  input  logic                            cfg_dat_fall,
  input  logic                            cfg_dbl_rate,
  input  logic                            cfg_upd_second,
  input  logic                            cfg_fp_inv,
  input  logic [$clog2(TS_PER_FRAME)-1:0] cfg_ts_ofs,
  input  logic [$clog2(BITS_PER_TS)-1:0]  cfg_bit_ofs,
  input  logic                            cfg_hiz,
  input  logic                            cfg_err_ie,
  input  logic                            err_clr,
  output logic [$clog2(TS_PER_FRAME)-1:0] ts_idx,
  input  logic [BITS_PER_TS-1:0]          ts_byte,
  input  logic [SIG_W-1:0]                ts_sig,
  output logic                            ser_dat,
  output logic                            ser_sig,
  output logic                            ser_oe,
  output logic                            err_flag,
  output logic                            irq
);

  localparam int TS_W  = $clog2(TS_PER_FRAME);
  localparam int BW    = $clog2(BITS_PER_TS);
  localparam int CNT_W = TS_W + BW;

  edge_sel_t        esel;
  logic             fs_ev, up_ev, fp_act;
  logic             fp_hit, shift_en;
  logic [CNT_W-1:0] cur_pos;

  assign esel = '{fs_fall: cfg_fp_fall, up_fall: cfg_dat_fall, fs_inv: cfg_fp_inv};

  tdm_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_fp_i(ser_fp_i),
    .sel(esel), .fs_ev(fs_ev), .up_ev(up_ev), .fp_act(fp_act)
  );

  tdm_rx_timing #(.TS_W(TS_W), .BW(BW)) u_tim (
    .clk(clk), .rst_n(rst_n), .fs_ev(fs_ev), .up_ev(up_ev), .fp_act(fp_act),
    .dbl_rate(cfg_dbl_rate), .upd_second(cfg_upd_second),
    .ts_ofs(cfg_ts_ofs), .bit_ofs(cfg_bit_ofs), .err_clr(err_clr),
    .cur_pos(cur_pos), .shift_en(shift_en), .fp_hit(fp_hit), .err_flag(err_flag)
  );

  assign ts_idx = cur_pos[CNT_W-1:BW];

  tdm_rx_shift #(.BITS_PER_TS(BITS_PER_TS), .SIG_W(SIG_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_pos(cur_pos[BW-1:0]),
    .ts_byte(ts_byte), .ts_sig(ts_sig), .ser_dat(ser_dat), .ser_sig(ser_sig)
  );

  assign ser_oe = ~cfg_hiz;
  assign irq    = err_flag & cfg_err_ie;

endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic fp_hit,
  input logic shift_en,
  input logic cfg_fp_fall,
  input logic cfg_dat_fall,
  input logic ser_dat,
  input logic ser_sig,
  input logic err_flag,
  input logic err_clr,
  input logic irq
);

  // R2 / R6: serial outputs move only on an update event
  a_r2_hold_between_updates: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> ($stable(ser_dat) && $stable(ser_sig)));

  // R3: with differing edge types, acceptance and update never coincide
  a_r3_pulse_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fp_fall != cfg_dat_fall) |-> !(fp_hit && shift_en));

  // R9: flag rises only after an accepted pulse
  a_r9_set_by_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(fp_hit));

  // R9: flag is sticky without a clear strobe
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  // R10: strobe clears when no pulse competes
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !fp_hit) |=> !err_flag);

  // R10: interrupt implies flag
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> err_flag);

endmodule

bind tdm_rx_port tdm_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fp_hit(fp_hit), .shift_en(shift_en),
  .cfg_fp_fall(cfg_fp_fall), .cfg_dat_fall(cfg_dat_fall),
  .ser_dat(ser_dat), .ser_sig(ser_sig), .err_flag(err_flag),
  .err_clr(err_clr), .irq(irq)
);

// File: tb/sim_tdm_rx_port.sv
module sim_tdm_rx_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_clk_i, ser_fp_i;
  logic       cfg_fp_fall, cfg_dat_fall, cfg_dbl_rate, cfg_upd_second, cfg_fp_inv;
  logic [4:0] cfg_ts_ofs;
  logic [2:0] cfg_bit_ofs;
  logic       cfg_hiz, cfg_err_ie, err_clr;
  logic [4:0] ts_idx;
  logic [7:0] ts_byte;
  logic [3:0] ts_sig;
  logic       ser_dat, ser_sig, ser_oe, err_flag, irq;

  logic [7:0] ts_mem [32];
  logic [3:0] sig_mem [32];

  int n_chk = 0;
  int n_fail = 0;
  int mis_d, mis_s;

  always #2 clk = ~clk;

  assign ts_byte = ts_mem[ts_idx];
  assign ts_sig  = sig_mem[ts_idx];

  tdm_rx_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_fp_i(ser_fp_i),
    .cfg_fp_fall(cfg_fp_fall), .cfg_dat_fall(cfg_dat_fall),
    .cfg_dbl_rate(cfg_dbl_rate), .cfg_upd_second(cfg_upd_second),
    .cfg_fp_inv(cfg_fp_inv), .cfg_ts_ofs(cfg_ts_ofs), .cfg_bit_ofs(cfg_bit_ofs),
    .cfg_hiz(cfg_hiz), .cfg_err_ie(cfg_err_ie), .err_clr(err_clr),
    .ts_idx(ts_idx), .ts_byte(ts_byte), .ts_sig(ts_sig),
    .ser_dat(ser_dat), .ser_sig(ser_sig), .ser_oe(ser_oe),
    .err_flag(err_flag), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 32; i++) begin
      ts_mem[i]  = 8'((i * 29 + seed * 7 + 3) ^ (i << 3));
      sig_mem[i] = 4'(i ^ seed);
    end
  endtask

  task automatic set_cfg(input bit fe, input bit de, input bit dbl, input bit sec,
                         input bit inv, input int tso, input int bo);
    cfg_fp_fall = fe; cfg_dat_fall = de; cfg_dbl_rate = dbl; cfg_upd_second = sec;
    cfg_fp_inv = inv; cfg_ts_ofs = 5'(tso); cfg_bit_ofs = 3'(bo);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ser_clk_i = 1'b0; ser_fp_i = cfg_fp_inv; err_clr = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit in_pulse(int e, int p, int hold);
    return (p >= 0) && (e >= p - 1) && (e <= p + 2 * (hold - 1) - 1);
  endfunction

  // Drives n serial clock edges (even index = rising); pulses accepted at
  // edges p1/p2; optionally compares both outputs to the expected stream.
  task automatic run_edges(input int n, input int p1, input int p2, input int hold, input bit chk);
    int ofs, step, first, j, q, b, ed, es;
    bit act;
    ofs   = int'(cfg_ts_ofs) * 8 + int'(cfg_bit_ofs);
    step  = cfg_dbl_rate ? 4 : 2;
    first = p1 + ((cfg_fp_fall != cfg_dat_fall) ? 1 : 0)
               + ((cfg_dbl_rate && cfg_upd_second) ? 2 : 0);
    mis_d = 0; mis_s = 0;
    for (int e = 0; e < n; e++) begin
      @(negedge clk);
      ser_clk_i = ~ser_clk_i;
      repeat (5) @(negedge clk);
      act = in_pulse(e, p1, hold) || in_pulse(e, p2, hold);
      ser_fp_i = act ^ cfg_fp_inv;
      repeat (2) @(negedge clk);
      if (chk && e >= first) begin
        j  = (e - first) / step;
        q  = (j - ofs) & 255;
        b  = q & 7;
        ed = int'(ts_mem[q >> 3][7 - b]);
        es = (b >= 4) ? int'(sig_mem[q >> 3][7 - b]) : 0;
        if (int'(ser_dat) != ed) begin
          if (mis_d == 0) $display("  data mismatch edge=%0d pos=%0d got=%0b", e, q, ser_dat);
          mis_d++;
        end
        if (int'(ser_sig) != es) mis_s++;
      end
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    fill(1);
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    cfg_hiz = 0; cfg_err_ie = 1;
    do_reset();
    check("R1 ser_dat after reset", int'(ser_dat), 0);
    check("R1 ser_sig after reset", int'(ser_sig), 0);
    check("R1 err_flag after reset", int'(err_flag), 0);
    check("R1 irq after reset", int'(irq), 0);
    check("R1 ser_oe after reset", int'(ser_oe), 1);
    cfg_err_ie = 0;
  endtask

  task automatic t_same_edge();
    fill(2); set_cfg(0, 0, 0, 0, 0, 0, 0); do_reset();
    run_edges(540, 4, -1, 1, 1);
    check("R2 MSB-first stream, same edge", mis_d, 0);
    check("R6 signaling stream, no offset", mis_s, 0);
    check("R9 first pulse not judged", int'(err_flag), 0);
  endtask

  task automatic t_ahead();
    fill(3); set_cfg(0, 1, 0, 0, 0, 0, 0); do_reset();
    run_edges(540, 4, -1, 1, 1);
    check("R3 early pulse stream", mis_d, 0);
  endtask

  task automatic t_ts_ofs();
    fill(4); set_cfg(1, 1, 0, 0, 0, 3, 0); do_reset();
    run_edges(540, 5, -1, 1, 1);
    check("R4 timeslot offset 3 stream", mis_d, 0);
    check("R6 signaling with timeslot offset", mis_s, 0);
    fill(9); set_cfg(0, 0, 0, 0, 0, 31, 0); do_reset();
    run_edges(540, 4, -1, 1, 1);
    check("R4 timeslot offset 31 stream", mis_d, 0);
  endtask

  task automatic t_bit_ofs();
    fill(5); set_cfg(1, 0, 0, 0, 0, 1, 5); do_reset();
    run_edges(540, 5, -1, 1, 1);
    check("R5 bit offset 5 stream", mis_d, 0);
    check("R6 signaling with bit offset", mis_s, 0);
  endtask

  task automatic t_invert();
    fill(6); set_cfg(0, 0, 0, 0, 1, 2, 3); do_reset();
    run_edges(540, 4, -1, 1, 1);
    check("R8 active-low pulse stream", mis_d, 0);
  endtask

  task automatic t_double();
    fill(7); set_cfg(0, 1, 1, 1, 0, 0, 2); do_reset();
    run_edges(1070, 4, -1, 2, 1);
    check("R7 double rate second edge stream", mis_d, 0);
    check("R12 held pulse accepted once (second edge)", mis_s, 0);
    fill(8); set_cfg(1, 1, 1, 0, 0, 1, 0); do_reset();
    run_edges(1070, 5, -1, 2, 1);
    check("R7 double rate first edge stream", mis_d, 0);
    check("R12 held pulse accepted once (first edge)", mis_s, 0);
  endtask

  task automatic t_grid_err();
    fill(10); set_cfg(0, 0, 0, 0, 0, 0, 0); cfg_err_ie = 0; do_reset();
    run_edges(600, 4, 516, 1, 1);
    check("R9 on-grid pulses stream", mis_d, 0);
    check("R9 on-grid pulse no error", int'(err_flag), 0);
    run_edges(20, 6, -1, 1, 0);
    check("R9 off-grid pulse sets flag", int'(err_flag), 1);
    check("R10 irq masked", int'(irq), 0);
    repeat (30) @(negedge clk);
    check("R9 flag sticky", int'(err_flag), 1);
    cfg_err_ie = 1;
    @(negedge clk);
    check("R10 irq enabled", int'(irq), 1);
    err_clr = 1;
    @(negedge clk);
    err_clr = 0;
    @(negedge clk);
    check("R10 flag cleared by strobe", int'(err_flag), 0);
    check("R10 irq drops after clear", int'(irq), 0);
    cfg_err_ie = 0;
  endtask

  task automatic t_hiz();
    cfg_hiz = 1;
    @(negedge clk);
    check("R11 hiz disables output", int'(ser_oe), 0);
    cfg_hiz = 0;
    @(negedge clk);
    check("R11 output enabled again", int'(ser_oe), 1);
  endtask

  initial begin
    rst_n = 1'b0; ser_clk_i = 1'b0; ser_fp_i = 1'b0; err_clr = 1'b0;
    cfg_hiz = 1'b0; cfg_err_ie = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    fill(0);
    t_reset();
    t_same_edge();
    t_ahead();
    t_ts_ofs();
    t_bit_ofs();
    t_invert();
    t_double();
    t_grid_err();
    t_hiz();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule